// File: doc/BRIEF.md
# Fractional Clock Divider Field Encoder

This block turns a requested output divide ratio into the three 16-bit configuration words that a synthesizer's output or feedback counter is loaded with. The ratio is an integer part plus a fraction in eighths, so the divide value is `int + frac/8`. The block works out the high and low counts, the odd-edge flag, the bypass flag, the fractional enable and fraction, the two waveform adjust flags and the fractional phase. In fractional mode it applies the count corrections the counter hardware needs rather than just halving the divider.

A request is a single-cycle `in_valid` pulse carrying `in_int` and `in_frac`. By default the words are registered, and they appear with a one-cycle `out_done` strobe on the clock edge after the request. A request with an integer part of zero is rejected: the block raises `out_err` for one cycle and leaves the words unchanged. Each word comes with a constant write mask that a downstream writer uses for read-modify-write. The parameter `OUT_REG` chooses between the registered variant and a purely combinational one.

Top module: `frac_div_encoder`

## Requirements
- R1: An integer part of 1 sets only the bypass flag (`cfg_word1` bit 6); every other field, including the fraction, is zero, whatever `in_frac` is.
- R2: With a zero fraction: high = int/2 in `cfg_word0` bits 11:6, low = int − high in bits 5:0, and edge = int mod 2 in `cfg_word1` bit 7. Fractional enable, fraction, waveform flags and phase are all zero.
- R3: With a nonzero fraction, fractional enable (`cfg_word1` bit 11) is set and the fraction appears in `cfg_word1` bits 14:12. High and low both start from int/2, and edge = int mod 2.
- R4: In fractional mode with an even integer part, high is one less than int/2 and the rising adjust flag (`cfg_word1` bit 10) is set. Otherwise that flag is clear.
- R5: In fractional mode, low is reduced by one when the integer part is even or when the fraction is 1.
- R6: The falling adjust flag (`cfg_word2` bit 10) is set in fractional mode when (int even) XOR (frac = 1), or when int = 2 and frac = 1.
- R7: The fractional phase in `cfg_word2` bits 13:11 equals edge×4 + frac/2, using integer division.
- R8: The masks are fixed: `cfg_mask0` = 0xEFFF, `cfg_mask1` = 0x7FFF, `cfg_mask2` = 0x3C00.
- R9: A valid request with a nonzero integer part updates all three words and pulses `out_done` for exactly one cycle, one clock after the request.
- R10: A valid request with a zero integer part pulses `out_err` one clock later. It gives no `out_done` and leaves the words unchanged.
- R11: During and right after reset, all words are zero and `out_done` and `out_err` are low.
- R12: A cycle with `in_valid` low gives neither strobe and leaves the words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| in_int | input | INT_W | Integer part of the divide ratio |
| in_frac | input | 3 | Fraction of the divide ratio in eighths |
| out_done | output | 1 | One-cycle strobe: new words are valid |
| out_err | output | 1 | One-cycle strobe: request rejected |
| cfg_word0 | output | 16 | High and low counts |
| cfg_word1 | output | 16 | Fraction, enable, rising flag, edge, bypass |
| cfg_word2 | output | 16 | Phase and falling flag |
| cfg_mask0 | output | 16 | Write mask for word 0 |
| cfg_mask1 | output | 16 | Write mask for word 1 |
| cfg_mask2 | output | 16 | Write mask for word 2 |

## Verification
Every result of a request, meaning the three words and whichever strobe applies, is due on the first rising edge after the request is presented. Nothing is due later than that. The bench drives each request on a falling edge and compares the outputs on the next falling edge against a behavioural model. That places each comparison exactly one register stage after its stimulus, and every cycle is checked, including idle and rejected ones. The sweep covers every integer part with every fraction, with idle cycles in between, so the hold behaviour is checked each time.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

   localparam int CNT_W  = 6;
   localparam int FRAC_W = 3;
   localparam int PHS_W  = 3;
   localparam int WORD_W = 16;

   localparam logic [WORD_W-1:0] MASK_CNT = 16'hEFFF;
   localparam logic [WORD_W-1:0] MASK_CTL = 16'h7FFF;
   localparam logic [WORD_W-1:0] MASK_PHS = 16'h3C00;

   typedef struct packed {
      logic [CNT_W-1:0]  hi_cnt;
      logic [CNT_W-1:0]  lo_cnt;
      logic              odd_edge;
      logic              bypass;
      logic              frac_en;
      logic [FRAC_W-1:0] frac;
      logic              rise_adj;
      logic              fall_adj;
      logic [PHS_W-1:0]  phase;
   } div_fields_t;

endpackage

// File: rtl/frac_div_calc.sv
module frac_div_calc
   import frac_div_pkg::*;
#(
   parameter int INT_W = 6
) (
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output div_fields_t       fields
);

   logic [CNT_W-1:0] half_c;
   logic [CNT_W-1:0] full_c;
   logic             is_odd;
   logic             frac_one;

   assign full_c   = CNT_W'(div_int);
   assign half_c   = CNT_W'(div_int >> 1);
   assign is_odd   = div_int[0];
   assign frac_one = (div_frac == FRAC_W'(1));

   always_comb begin
      fields = '0;
      if (div_int == INT_W'(1)) begin
         fields.bypass = 1'b1;
      end else if (div_frac == '0) begin
         fields.hi_cnt   = half_c;
         fields.lo_cnt   = full_c - half_c;
         fields.odd_edge = is_odd;
      end else begin
         fields.frac_en  = 1'b1;
         fields.frac     = div_frac;
         fields.odd_edge = is_odd;
         fields.hi_cnt   = half_c;
         fields.lo_cnt   = half_c;
         if (!is_odd) begin
            fields.hi_cnt   = half_c - CNT_W'(1);
            fields.rise_adj = 1'b1;
         end
         if (!is_odd || frac_one)
            fields.lo_cnt = half_c - CNT_W'(1);
         fields.fall_adj = ((!is_odd) ^ frac_one) ||
                           (div_int == INT_W'(2) && frac_one);
         fields.phase    = {is_odd, div_frac[FRAC_W-1:1]};
      end
   end

endmodule

// File: rtl/frac_div_pack.sv
module frac_div_pack
   import frac_div_pkg::*;
(
   input  div_fields_t       fields,
   output logic [WORD_W-1:0] w_cnt,
   output logic [WORD_W-1:0] w_ctl,
   output logic [WORD_W-1:0] w_phs
);

   assign w_cnt = {4'b0, fields.hi_cnt, fields.lo_cnt};
   assign w_ctl = {1'b0, fields.frac, fields.frac_en, fields.rise_adj, 2'b0,
                   fields.odd_edge, fields.bypass, 6'b0};
   assign w_phs = {2'b0, fields.phase, fields.fall_adj, 10'b0};

endmodule

// File: rtl/frac_div_encoder.sv
module frac_div_encoder
   import frac_div_pkg::*;
#(
   parameter int INT_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INT_W-1:0]  in_int,
   input  logic [2:0]        in_frac,
   output logic              out_done,
   output logic              out_err,
   output logic [15:0]       cfg_word0,
   output logic [15:0]       cfg_word1,
   output logic [15:0]       cfg_word2,
   output logic [15:0]       cfg_mask0,
   output logic [15:0]       cfg_mask1,
   output logic [15:0]       cfg_mask2
);

   if (INT_W < 2 || INT_W > CNT_W) begin : g_bad_width
      $error("frac_div_encoder: INT_W must lie in 2..CNT_W");
   end

   div_fields_t       fields;
   logic [WORD_W-1:0] nxt_cnt, nxt_ctl, nxt_phs;
   logic              accept, reject;

   assign accept = in_valid && (in_int != '0);
   assign reject = in_valid && (in_int == '0);

   frac_div_calc #(.INT_W(INT_W)) u_calc (
      .div_int  (in_int),
      .div_frac (in_frac),
      .fields   (fields)
   );

   frac_div_pack u_pack (
      .fields (fields),
      .w_cnt  (nxt_cnt),
      .w_ctl  (nxt_ctl),
      .w_phs  (nxt_phs)
   );

   assign cfg_mask0 = MASK_CNT;
   assign cfg_mask1 = MASK_CTL;
   assign cfg_mask2 = MASK_PHS;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_done  <= 1'b0;
            out_err   <= 1'b0;
            cfg_word0 <= '0;
            cfg_word1 <= '0;
            cfg_word2 <= '0;
         end else begin
            out_done <= accept;
            out_err  <= reject;
            if (accept) begin
               cfg_word0 <= nxt_cnt;
               cfg_word1 <= nxt_ctl;
               cfg_word2 <= nxt_phs;
            end
         end
      end

      assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
         accept |=> out_done && !out_err);
      assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
         reject |=> out_err && !out_done && $stable(cfg_word0) && $stable(cfg_word1)
                    && $stable(cfg_word2));
      assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_done && !out_err && $stable(cfg_word0)
                       && $stable(cfg_word1) && $stable(cfg_word2));
      assert_int_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_done && !cfg_word1[11] && !cfg_word1[6] |->
            (7'(cfg_word0[11:6]) + 7'(cfg_word0[5:0])) == 7'($past(in_int)));
      assert_bypass_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
         out_done && cfg_word1[6] |-> cfg_word0 == '0 && cfg_word2 == '0
                                      && $countones(cfg_word1) == 1);
   end else begin : g_comb
      assign out_done  = accept;
      assign out_err   = reject;
      assign cfg_word0 = nxt_cnt;
      assign cfg_word1 = nxt_ctl;
      assign cfg_word2 = nxt_phs;
   end

endmodule

// File: tb/tb_frac_div_encoder.sv
module tb_frac_div_encoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [5:0]  in_int;
   logic [2:0]  in_frac;
   logic        out_done, out_err;
   logic [15:0] cfg_word0, cfg_word1, cfg_word2;
   logic [15:0] cfg_mask0, cfg_mask1, cfg_mask2;

   always #5 clk = ~clk;

   frac_div_encoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
      .in_frac(in_frac), .out_done(out_done), .out_err(out_err),
      .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2),
      .cfg_mask0(cfg_mask0), .cfg_mask1(cfg_mask1), .cfg_mask2(cfg_mask2)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] e_w0 = '0, e_w1 = '0, e_w2 = '0;

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(int d, int f, output logic [15:0] a,
                                 output logic [15:0] b, output logic [15:0] c);
      int hi = 0, lo = 0, ed = 0, by = 0, fe = 0, wr = 0, wf = 0, ph = 0, fr = 0;
      if (d == 1) by = 1;
      else if (f == 0) begin
         hi = d / 2; ed = d % 2; lo = d - hi;
      end else begin
         fe = 1; fr = f; hi = d / 2; ed = d % 2; lo = hi;
         if (ed == 0) begin hi = hi - 1; wr = 1; end
         if (ed == 0 || f == 1) lo = lo - 1;
         wf = (((ed == 0) != (f == 1)) || (d == 2 && f == 1)) ? 1 : 0;
         ph = ed * 4 + f / 2;
      end
      a = 16'(hi * 64 + lo);
      b = 16'(fr * 4096 + fe * 2048 + wr * 1024 + ed * 128 + by * 64);
      c = 16'(ph * 2048 + wf * 1024);
   endfunction

   // called at a falling edge; drives, then checks at the next falling edge
   task automatic step(bit v, int d, int f);
      bit acc = v && (d != 0);
      string t0, t1, t2;
      in_valid = v; in_int = 6'(d); in_frac = 3'(f);
      if (acc) model(d, f, e_w0, e_w1, e_w2);
      if (!acc)       begin t0 = v ? "R10" : "R12"; t1 = t0; t2 = t0; end
      else if (d == 1) begin t0 = "R1"; t1 = "R1"; t2 = "R1"; end
      else if (f == 0) begin t0 = "R2"; t1 = "R2"; t2 = "R2"; end
      else begin t0 = "R3/R4/R5"; t1 = "R3/R4"; t2 = "R6/R7"; end
      @(negedge clk);
      chk("R9 done", {15'b0, out_done}, {15'b0, acc});
      chk("R10 err", {15'b0, out_err}, {15'b0, v && d == 0});
      chk(t0, cfg_word0, e_w0);
      chk(t1, cfg_word1, e_w1);
      chk(t2, cfg_word2, e_w2);
      chk("R8", cfg_mask0, 16'hEFFF);
      chk("R8", cfg_mask1, 16'h7FFF);
      chk("R8", cfg_mask2, 16'h3C00);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_int = '0; in_frac = '0;
      repeat (3) @(negedge clk);
      chk("R11 word0", cfg_word0, 16'h0);
      chk("R11 word1", cfg_word1, 16'h0);
      chk("R11 word2", cfg_word2, 16'h0);
      chk("R11 strobes", {14'b0, out_done, out_err}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 after reset", cfg_word0 | cfg_word1 | cfg_word2, 16'h0);
      step(1'b0, 9, 3);
      step(1'b1, 0, 4);      // R10 reject from reset state
      step(1'b1, 1, 5);      // R1 fraction ignored
      step(1'b1, 2, 1);      // R6 special case
      step(1'b1, 0, 0);      // R10 hold previous words
      step(1'b1, 3, 1);
      step(1'b1, 63, 7);
      for (int d = 0; d < 64; d++) begin
         for (int f = 0; f < 8; f++) step(1'b1, d, f);
         step(1'b0, d, 0);
      end
      step(1'b0, 0, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule